// File: doc/BRIEF.md
# Multichannel Sample Streamer

This block takes eight 16-bit signed sample inputs and, on a tick whose period is programmable, copies all of them at once into a scan. It then writes that scan, one word per cycle, into a downstream FIFO through a valid/full write port. In unpacked format each sample fills its own sign-extended 32-bit word. In packed format two samples in channel order share one word, so a scan is eight words or four.

Nothing is written until the host issues a start command, so the receiving side can be opened first. A start command picks continuous operation or a finite burst of N scans. A finite burst stops on its own and waits for the next start, which makes retriggerable bursts. Any write that meets a full FIFO is fatal: acquisition halts and a sticky overflow flag is raised. A tick that arrives while the previous scan is still being written is treated the same way. A scan counter shows how many scans have completed since the last start.

Top module: `sample_streamer`

## Requirements
- R1: No FIFO write occurs before a start command is accepted. A start is accepted only while the block is stopped and overflow is clear. A start pulse that arrives while acquisition is running has no effect.
- R2: While running, a scan begins every `tick_period` cycles. The first scan begins `tick_period` cycles after the accepted start.
- R3: All eight inputs are captured in the same cycle when a scan begins. Channel c occupies `samples[16c+15:16c]`, and words leave in channel order 0 to 7.
- R4: In unpacked format each word is the channel sample in bits 15:0, with bits 31:16 all equal to bit 15 of that sample.
- R5: In packed format word k of a scan (k = 0..3) holds channel 2k in bits 15:0 and channel 2k+1 in bits 31:16.
- R6: If `fifo_valid` is high while `fifo_full` is high, that word is not taken. In the next cycle `overflow` is 1, `running` is 0, no further writes occur, and `scan_count` keeps its value.
- R7: `overflow` stays 1 until `clear` is pulsed. While it is 1, start commands are ignored.
- R8: A tick that arrives while a scan is still being written sets `overflow` and stops acquisition. The word being written in that cycle is still delivered, and a scan finishing in that cycle is still counted.
- R9: In finite mode acquisition stops by itself after `scan_limit` complete scans. A later start runs a fresh burst of the same length.
- R10: `scan_count` becomes 0 when a start is accepted and increments once for each completed scan.
- R11: The format and mode inputs are captured when a start is accepted and apply to the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start command |
| clear | input | 1 | One-cycle overflow clear |
| finite_mode | input | 1 | 1: stop after `scan_limit` scans |
| packed_mode | input | 1 | 1: two samples per word |
| tick_period | input | 32 | Scan period in cycles |
| scan_limit | input | 32 | Scans per finite burst |
| samples | input | 128 | Eight 16-bit samples, channel c at bits 16c+15:16c |
| fifo_data | output | 32 | Word offered to the FIFO |
| fifo_valid | output | 1 | Write request |
| fifo_full | input | 1 | FIFO cannot accept a word |
| overflow | output | 1 | Sticky fault flag |
| running | output | 1 | Acquisition active |
| scan_count | output | 32 | Completed scans since last start |

## Verification
The tick that paces scans and the final word of an ongoing scan can fall in the same cycle. That cycle is then both a completion and an overrun. The bench provokes it by running unpacked scans with an eight-cycle period. It then expects all eight words to reach the scoreboard, the scan counter to read 1 and the overflow flag to be set. A second coincidence, a pending word meeting a full FIFO, is provoked by raising full between scans and judged by the counter holding at its old value while no later word appears.

// File: rtl/sample_streamer.sv
module sample_streamer #(
  parameter int NCH = 8,
  parameter int SW  = 16,
  parameter int CW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear,
  input  logic              finite_mode,
  input  logic              packed_mode,
  input  logic [CW-1:0]     tick_period,
  input  logic [CW-1:0]     scan_limit,
  input  logic [NCH*SW-1:0] samples,
  output logic [2*SW-1:0]   fifo_data,
  output logic              fifo_valid,
  input  logic              fifo_full,
  output logic              overflow,
  output logic              running,
  output logic [CW-1:0]     scan_count
);
  localparam int IW = $clog2(NCH);
  localparam logic [IW-1:0] LAST_U = IW'(NCH - 1);
  localparam logic [IW-1:0] LAST_P = IW'(NCH / 2 - 1);

  logic [CW-1:0]     cnt;
  logic [NCH*SW-1:0] snap;
  logic [IW-1:0]     idx;
  logic              busy, pk, fin;
  logic [SW-1:0]     lo;

  wire tick  = running && (cnt == '0);
  wire go    = start && !running && !overflow;
  wire acc   = busy && !fifo_full;
  wire last  = (idx == (pk ? LAST_P : LAST_U));
  wire done  = acc && last;
  wire fault = (busy && fifo_full) || (tick && busy);

  assign lo         = snap[int'(idx)*SW +: SW];
  assign fifo_data  = pk ? snap[int'(idx[IW-2:0])*2*SW +: 2*SW] : {{SW{lo[SW-1]}}, lo};
  assign fifo_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      snap       <= '0;
      idx        <= '0;
      busy       <= 1'b0;
      pk         <= 1'b0;
      fin        <= 1'b0;
      overflow   <= 1'b0;
      running    <= 1'b0;
      scan_count <= '0;
    end else begin
      if (clear) overflow <= 1'b0;
      if (go) begin
        running    <= 1'b1;
        pk         <= packed_mode;
        fin        <= finite_mode;
        scan_count <= '0;
        cnt        <= tick_period - 1'b1;
      end else if (running) begin
        cnt <= tick ? tick_period - 1'b1 : cnt - 1'b1;
      end
      if (done) begin
        busy       <= 1'b0;
        idx        <= '0;
        scan_count <= scan_count + 1'b1;
        if (fin && (scan_count + 1'b1 >= scan_limit)) running <= 1'b0;
      end else if (acc) begin
        idx <= idx + 1'b1;
      end
      if (tick && !busy) begin
        busy <= 1'b1;
        idx  <= '0;
        snap <= samples;
      end
      if (fault) begin
        overflow <= 1'b1;
        running  <= 1'b0;
        busy     <= 1'b0;
        idx      <= '0;
      end
    end
  end

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid |-> running);
  assert_full_fatal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && fifo_full |=> overflow && !running && !fifo_valid);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clear |=> overflow);
  assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !running);
  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && busy |=> overflow);
  assert_count_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> scan_count == '0);
endmodule

// File: tb/sim_sample_streamer.sv
module sim_sample_streamer;
  logic clk = 1'b0;
  logic rst_n, start, clear, finite_mode, packed_mode, fifo_full;
  logic [31:0] tick_period, scan_limit;
  logic [127:0] samples;
  logic [31:0] fifo_data, scan_count;
  logic fifo_valid, overflow, running;
  logic [15:0] ch [8];

  always #5 clk = ~clk;

  always_comb
    for (int c = 0; c < 8; c++) samples[c*16 +: 16] = ch[c];

  sample_streamer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .finite_mode(finite_mode), .packed_mode(packed_mode),
    .tick_period(tick_period), .scan_limit(scan_limit), .samples(samples),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_full(fifo_full),
    .overflow(overflow), .running(running), .scan_count(scan_count)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, last_rise = -1, gap_exp = 0;
  logic [31:0] exp_q [$];
  string cur_tag = "R3";
  logic prev_v = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (fifo_valid && !prev_v) begin
        if (gap_exp > 0 && last_rise >= 0)
          chk(cyc - last_rise == gap_exp, "R2 scan spacing", cyc - last_rise, gap_exp);
        last_rise = cyc;
      end
      if (fifo_valid && !fifo_full) begin
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected write", fifo_data, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(fifo_data == e, cur_tag, fifo_data, e);
        end
      end
      prev_v = fifo_valid;
    end
  end

  task automatic push_scan(input int seed, input bit pkd);
    for (int c = 0; c < 8; c++) begin
      logic [15:0] v;
      v = 16'(seed * 4099 + c * 7919);
      v[15] = c[0];
      ch[c] = v;
    end
    if (pkd) for (int k = 0; k < 4; k++) exp_q.push_back({ch[2*k+1], ch[2*k]});
    else     for (int c = 0; c < 8; c++) exp_q.push_back({{16{ch[c][15]}}, ch[c]});
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; clear = 1'b0; finite_mode = 1'b0;
    packed_mode = 1'b0; fifo_full = 1'b0; tick_period = 32'd12; scan_limit = 32'd0;
    for (int c = 0; c < 8; c++) ch[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_valid == 1'b0, "R1 reset valid", 32'(fifo_valid), 32'h0);
    chk(overflow == 1'b0, "R7 reset overflow", 32'(overflow), 32'h0);
    chk(scan_count == 32'h0, "R10 reset count", scan_count, 32'h0);
    repeat (40) @(negedge clk);
    chk(running == 1'b0, "R1 idle before start", 32'(running), 32'h0);

    // continuous, unpacked: R2 R3 R4 R10
    cur_tag = "R3/R4 unpacked word";
    gap_exp = 12; last_rise = -1;
    push_scan(1, 1'b0);
    pulse_start();
    wait_drain();
    push_scan(2, 1'b0);
    wait_drain();
    pulse_start();
    chk(scan_count == 32'd2, "R1 start ignored while running", scan_count, 32'd2);
    push_scan(3, 1'b0);
    wait_drain();
    chk(scan_count == 32'd3, "R10 per-scan increment", scan_count, 32'd3);

    // full FIFO fatal: R6 R7
    fifo_full = 1'b1;
    repeat (24) @(negedge clk);
    chk(overflow == 1'b1, "R6 overflow on full", 32'(overflow), 32'h1);
    chk(running == 1'b0, "R6 stopped on full", 32'(running), 32'h0);
    chk(scan_count == 32'd3, "R6 count held", scan_count, 32'd3);
    fifo_full = 1'b0;
    repeat (30) @(negedge clk);
    chk(fifo_valid == 1'b0, "R6 no writes after fault", 32'(fifo_valid), 32'h0);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(running == 1'b0, "R7 start ignored in overflow", 32'(running), 32'h0);
    chk(overflow == 1'b1, "R7 overflow sticky", 32'(overflow), 32'h1);
    pulse_clear();
    chk(overflow == 1'b0, "R7 clear releases", 32'(overflow), 32'h0);
    gap_exp = 0;

    // finite, packed, retriggered: R5 R9 R10 R11
    cur_tag = "R5/R11 packed word";
    tick_period = 32'd7; scan_limit = 32'd2; finite_mode = 1'b1; packed_mode = 1'b1;
    push_scan(4, 1'b1);
    pulse_start();
    packed_mode = 1'b0;
    chk(scan_count == 32'd0, "R10 zero on start", scan_count, 32'd0);
    wait_drain();
    push_scan(5, 1'b1);
    wait_drain();
    repeat (30) @(negedge clk);
    chk(running == 1'b0, "R9 burst ended", 32'(running), 32'h0);
    chk(scan_count == 32'd2, "R9 burst length", scan_count, 32'd2);
    packed_mode = 1'b1;
    push_scan(6, 1'b1);
    pulse_start();
    chk(scan_count == 32'd0, "R10 zero on retrigger", scan_count, 32'd0);
    wait_drain();
    push_scan(7, 1'b1);
    wait_drain();
    repeat (20) @(negedge clk);
    chk(running == 1'b0, "R9 second burst ended", 32'(running), 32'h0);
    chk(scan_count == 32'd2, "R9 second burst length", scan_count, 32'd2);

    // overrun: tick meets last word, R8
    cur_tag = "R8 words before overrun";
    tick_period = 32'd8; finite_mode = 1'b0; packed_mode = 1'b0;
    push_scan(8, 1'b0);
    pulse_start();
    wait_drain();
    repeat (5) @(negedge clk);
    chk(overflow == 1'b1, "R8 overrun flagged", 32'(overflow), 32'h1);
    chk(scan_count == 32'd1, "R8 finishing scan counted", scan_count, 32'd1);
    chk(running == 1'b0, "R8 stopped", 32'(running), 32'h0);
    repeat (30) @(negedge clk);
    pulse_clear();
    chk(overflow == 1'b0, "R7 clear after overrun", 32'(overflow), 32'h0);

    summary();
    $finish;
  end
endmodule